// File: doc/BRIEF.md
# Serial Memory Slave with Transfer Pause

This block is the serial front end of a small byte-addressed memory. It acts as a mode-0 SPI slave. A host lowers the active-low select, shifts a one-byte command into `si_i`, and for array access then shifts a 16-bit address with the most significant bit first. After that it streams data bytes in either direction. A status byte carries a protect-lock bit, two region-protect bits and the write-enable latch. A write-protect pin can freeze the status byte while the lock bit is set.

A low level on the pause input freezes a transfer at any bit without losing its state. While paused, serial clock and select activity is ignored and the output is released. When the pause input returns high, the transfer resumes at the bit where it stopped. All pins are sampled on the system clock `clk_i` and must already be synchronous to it. Each serial clock level lasts at least two system cycles. The logic is fully static, so the serial clock may stop for any length of time.

Top module: `spi_hold_mem`

## Requirements
- R1: While `cs_ni` is high, `standby_o` is 1 and `so_oe_o` is 0. Serial clock and data activity in that state changes no state, so a write-enable command clocked in then leaves the latch clear.
- R2: A command is decoded only from the first byte after a falling edge of `cs_ni`. Later bytes in the same frame after a one-byte command are ignored. The command codes are: 06h sets the write-enable latch, 04h clears it, 05h reads status, 01h writes status, 03h reads the array and 02h writes the array.
- R3: `si_i` is taken on rising serial clock edges. Read data leaves on `so_o` with the most significant bit first, and it changes only after falling serial clock edges. The first data bit appears after the falling edge that follows the last address bit. `so_oe_o` is high while read bits are being shifted.
- R4: Writes to the array and to the status byte take effect only while the write-enable latch is set. When `cs_ni` rises at the end of any 02h or 01h frame, the latch clears.
- R5: During streaming reads and writes the address increments by one per byte and wraps from DEPTH-1 to 0.
- R6: The status byte reads as bit 7 = protect lock, bits 3:2 = region protect, bit 1 = write-enable latch, with all other bits 0. It reads 00h after reset.
- R7: When `wp_ni` is low and the protect-lock bit is 1, a status write leaves the status byte unchanged.
- R8: Region protect blocks array writes as follows: 00 protects nothing, 01 protects the top quarter, 10 protects the top half and 11 protects the whole array. Unprotected bytes in the same stream are still written.
- R9: While `hold_ni` is low, `so_oe_o` is 0 and serial clock and select edges are ignored. When it returns high, the transfer continues at the same bit with the same data.
- R10: Address bits above log2(DEPTH) are ignored, so such addresses alias into the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock sampling all pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Select, active low; frames a command |
| sck_i | input | 1 | Serial clock, mode 0 |
| si_i | input | 1 | Serial data in |
| wp_ni | input | 1 | Status write-protect pin, active low |
| hold_ni | input | 1 | Transfer pause, active low |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for `so_o` |
| standby_o | output | 1 | High while deselected |

## Verification
Most wrong internal states show up at the ports within one byte time. A bit counter off by one misplaces read data by one bit position on the very next read byte. A wrong write-enable latch or region-protect decode shows up only on a later read or status read, so every write is followed by a read-back. Pause faults appear as a moving output during the pause, or as a shifted byte after resume. Those are caught within the byte in which the pause happens.

// File: rtl/spi_hold_mem_pkg.sv
package spi_hold_mem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_RD, ST_WR, ST_RDSR, ST_WRSR, ST_DONE
  } st_e;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRIT = 8'h02;

  // top two address bits against region-protect code
  function automatic logic region_locked(input logic [1:0] bp, input logic [1:0] top2);
    case (bp)
      2'b01:   return top2 == 2'b11;
      2'b10:   return top2[1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/spi_hold_mem_edge.sv
module spi_hold_mem_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic hold_ni,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic cs_q, sck_q;

  // pin history frozen while paused
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else if (hold_ni) begin
      cs_q  <= cs_ni;
      sck_q <= sck_i;
    end
  end

  assign start_o = hold_ni & cs_q & ~cs_ni;
  assign stop_o  = hold_ni & ~cs_q & cs_ni;
  assign rise_o  = hold_ni & ~cs_ni & ~sck_q & sck_i;
  assign fall_o  = hold_ni & ~cs_ni & sck_q & ~sck_i;
endmodule

// File: rtl/spi_hold_mem_array.sv
module spi_hold_mem_array #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/spi_hold_mem.sv
module spi_hold_mem
  import spi_hold_mem_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  input  logic wp_ni,
  input  logic hold_ni,
  output logic so_o,
  output logic so_oe_o,
  output logic standby_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int ABITS = 16;
  localparam logic [AW-1:0] A_ONE = AW'(1);
  localparam logic [3:0] ALAST = 4'(ABITS - 1);

  st_e           state_q;
  logic [3:0]    bit_cnt_q;
  logic [7:0]    sh_q, out_sh_q;
  logic [2:0]    out_cnt_q;
  logic [AW-1:0] addr_q;
  logic          is_rd_q, wr_seen_q, wel_q, wpen_q, so_q, out_live_q;
  logic [1:0]    bp_q;

  logic start, stop, rise, fall;
  logic [7:0] sh_nx, rdata, status, cur;
  logic byte_done, mem_we;

  spi_hold_mem_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_ni  (cs_ni),
    .sck_i  (sck_i),
    .hold_ni(hold_ni),
    .start_o(start),
    .stop_o (stop),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign sh_nx     = {sh_q[6:0], si_i};
  assign byte_done = bit_cnt_q[2:0] == 3'd7;
  assign status    = {wpen_q, 3'b000, bp_q, wel_q, 1'b0};
  assign mem_we    = rise && state_q == ST_WR && byte_done && wel_q &&
                     !region_locked(bp_q, addr_q[AW-1 -: 2]);
  assign cur       = (out_cnt_q == 3'd0) ? ((state_q == ST_RD) ? rdata : status) : out_sh_q;

  spi_hold_mem_array #(.DEPTH(DEPTH), .DW(8)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mem_we),
    .addr_i (addr_q),
    .wdata_i(sh_nx),
    .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      sh_q       <= '0;
      out_sh_q   <= '0;
      out_cnt_q  <= '0;
      addr_q     <= '0;
      is_rd_q    <= 1'b0;
      wr_seen_q  <= 1'b0;
      wel_q      <= 1'b0;
      wpen_q     <= 1'b0;
      bp_q       <= '0;
      so_q       <= 1'b0;
      out_live_q <= 1'b0;
    end else if (start) begin
      state_q    <= ST_CMD;
      bit_cnt_q  <= '0;
      out_cnt_q  <= '0;
      wr_seen_q  <= 1'b0;
      out_live_q <= 1'b0;
    end else if (stop) begin
      state_q    <= ST_IDLE;
      out_live_q <= 1'b0;
      if (wr_seen_q) wel_q <= 1'b0;
    end else if (rise) begin
      unique case (state_q)
        ST_CMD: begin
          sh_q      <= sh_nx;
          bit_cnt_q <= bit_cnt_q + 4'd1;
          if (byte_done) begin
            bit_cnt_q <= '0;
            unique case (sh_nx)
              OP_WREN: begin wel_q <= 1'b1; state_q <= ST_DONE; end
              OP_WRDI: begin wel_q <= 1'b0; state_q <= ST_DONE; end
              OP_RDSR: state_q <= ST_RDSR;
              OP_WRSR: begin state_q <= ST_WRSR; wr_seen_q <= 1'b1; end
              OP_READ: begin state_q <= ST_ADDR; is_rd_q <= 1'b1; end
              OP_WRIT: begin state_q <= ST_ADDR; is_rd_q <= 1'b0; wr_seen_q <= 1'b1; end
              default: state_q <= ST_DONE;
            endcase
          end
        end
        ST_ADDR: begin
          addr_q    <= {addr_q[AW-2:0], si_i};  // high address bits fall off
          bit_cnt_q <= bit_cnt_q + 4'd1;
          if (bit_cnt_q == ALAST) begin
            bit_cnt_q <= '0;
            state_q   <= is_rd_q ? ST_RD : ST_WR;
          end
        end
        ST_WR: begin
          sh_q      <= sh_nx;
          bit_cnt_q <= bit_cnt_q + 4'd1;
          if (byte_done) begin
            bit_cnt_q <= '0;
            addr_q    <= addr_q + A_ONE;
          end
        end
        ST_WRSR: begin
          sh_q      <= sh_nx;
          bit_cnt_q <= bit_cnt_q + 4'd1;
          if (byte_done) begin
            bit_cnt_q <= '0;
            state_q   <= ST_DONE;
            if (wel_q && !(wpen_q && !wp_ni)) begin
              wpen_q <= sh_nx[7];
              bp_q   <= sh_nx[3:2];
            end
          end
        end
        default: ;
      endcase
    end else if (fall && (state_q == ST_RD || state_q == ST_RDSR)) begin
      so_q       <= cur[7];
      out_sh_q   <= {cur[6:0], 1'b0};
      out_cnt_q  <= out_cnt_q + 3'd1;
      out_live_q <= 1'b1;
      if (out_cnt_q == 3'd7 && state_q == ST_RD) addr_q <= addr_q + A_ONE;
    end
  end

  assign so_o      = so_q;
  assign so_oe_o   = out_live_q & hold_ni & ~cs_ni & (state_q == ST_RD || state_q == ST_RDSR);
  assign standby_o = cs_ni;
endmodule

// File: rtl/spi_hold_mem_chk.sv
module spi_hold_mem_chk
  import spi_hold_mem_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       sck_i,
  input logic       wp_ni,
  input logic       hold_ni,
  input logic       so_o,
  input logic       so_oe_o,
  input logic       standby_o,
  input st_e        state_q,
  input logic [3:0] bit_cnt_q,
  input logic       wpen_q,
  input logic [1:0] bp_q
);
  p_deselect_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> (standby_o && !so_oe_o));

  p_out_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(so_oe_o) && so_oe_o && so_o != $past(so_o)) |-> !$past(sck_i));

  p_pause_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_ni |-> !so_oe_o);

  p_pause_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!hold_ni) |-> ($stable(bit_cnt_q) && $stable(state_q)));

  p_lock_status_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!wp_ni && wpen_q) |-> ($stable(wpen_q) && $stable(bp_q)));
endmodule

bind spi_hold_mem spi_hold_mem_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .sck_i    (sck_i),
  .wp_ni    (wp_ni),
  .hold_ni  (hold_ni),
  .so_o     (so_o),
  .so_oe_o  (so_oe_o),
  .standby_o(standby_o),
  .state_q  (state_q),
  .bit_cnt_q(bit_cnt_q),
  .wpen_q   (wpen_q),
  .bp_q     (bp_q)
);

// File: tb/spi_hold_mem_test.sv
module spi_hold_mem_test;
  localparam int DEPTH = 256;
  localparam int HP = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1, hold_n = 1'b1;
  logic so, so_oe, standby;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mem_m [DEPTH];
  logic wel_m = 1'b0, wpen_m = 1'b0;
  logic [1:0] bp_m = 2'b00;
  logic [7:0] buf_d [8];

  always #5 clk = ~clk;

  spi_hold_mem #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .wp_ni(wp_n), .hold_ni(hold_n), .so_o(so), .so_oe_o(so_oe), .standby_o(standby)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(hold_n) if (sck === 1'b1) chk("R9 pause moved while sck high", 16'd1, 16'd0);

  function automatic logic prot_m(input logic [1:0] bp, input logic [7:0] a);
    case (bp)
      2'b01:   return a >= 8'hC0;
      2'b10:   return a >= 8'h80;
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] sr_m();
    return {wpen_m, 3'b000, bp_m, wel_m, 1'b0};
  endfunction

  task automatic wait_c(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_pause();
    hold_n = 1'b0;
    wait_c(HP);
    chk("R9 output released in pause", 16'(so_oe), 16'd0);
    for (int k = 0; k < 3; k++) begin
      sck = 1'b1; si = ~si; wait_c(HP);
      sck = 1'b0; wait_c(HP);
    end
    hold_n = 1'b1;
    wait_c(HP);
  endtask

  task automatic byte_x(input logic [7:0] tx, input int pause_at, input bit want_oe,
                        output logic [7:0] rx);
    for (int i = 0; i < 8; i++) begin
      if (i == pause_at) do_pause();
      si = tx[7-i];
      wait_c(HP);
      rx[7-i] = so;
      if (want_oe) chk("R3 enable while shifting", 16'(so_oe), 16'd1);
      sck = 1'b1; wait_c(HP);
      sck = 1'b0;
    end
    wait_c(1);
  endtask

  task automatic cs_lo();
    cs_n = 1'b0; wait_c(HP);
  endtask

  task automatic cs_hi();
    wait_c(HP); cs_n = 1'b1; wait_c(HP);
  endtask

  task automatic op1(input logic [7:0] op);
    logic [7:0] r;
    cs_lo(); byte_x(op, 8, 1'b0, r); cs_hi();
    if (op == 8'h06) wel_m = 1'b1;
    if (op == 8'h04) wel_m = 1'b0;
  endtask

  task automatic rdsr(output logic [7:0] v);
    logic [7:0] r;
    cs_lo(); byte_x(8'h05, 8, 1'b0, r); byte_x(8'h00, 8, 1'b1, v); cs_hi();
  endtask

  task automatic sr_chk(input string req);
    logic [7:0] v;
    rdsr(v);
    chk(req, 16'(v), 16'(sr_m()));
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    cs_lo(); byte_x(8'h01, 8, 1'b0, r); byte_x(v, 8, 1'b0, r); cs_hi();
    if (wel_m && !(wpen_m && !wp_n)) begin wpen_m = v[7]; bp_m = v[3:2]; end
    wel_m = 1'b0;
  endtask

  task automatic wr_mem(input logic [15:0] a, input int n);
    logic [7:0] r;
    cs_lo(); byte_x(8'h02, 8, 1'b0, r); byte_x(a[15:8], 8, 1'b0, r); byte_x(a[7:0], 8, 1'b0, r);
    for (int i = 0; i < n; i++) begin
      byte_x(buf_d[i], 8, 1'b0, r);
      if (wel_m && !prot_m(bp_m, 8'(a[7:0] + 8'(i)))) mem_m[8'(a[7:0] + 8'(i))] = buf_d[i];
    end
    cs_hi();
    wel_m = 1'b0;
  endtask

  task automatic rd_mem(input logic [15:0] a, input int n, input int pb, input int pbit,
                        input string req);
    logic [7:0] r;
    cs_lo(); byte_x(8'h03, 8, 1'b0, r); byte_x(a[15:8], 8, 1'b0, r); byte_x(a[7:0], 8, 1'b0, r);
    for (int i = 0; i < n; i++) begin
      byte_x(8'h00, (i == pb) ? pbit : 8, 1'b1, r);
      chk(req, 16'(r), 16'(mem_m[8'(a[7:0] + 8'(i))]));
    end
    cs_hi();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog expired", 16'd1, 16'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'h00;
    void'($urandom(32'h5EED_0042));
    wait_c(5);
    rst_n = 1'b1;
    wait_c(3);

    // R1 R6 reset state
    chk("R1 standby after reset", 16'(standby), 16'd1);
    chk("R1 no drive after reset", 16'(so_oe), 16'd0);
    sr_chk("R6 status after reset");

    // R1 deselected activity ignored
    byte_x(8'h06, 8, 1'b0, r);
    chk("R1 no drive while deselected", 16'(so_oe), 16'd0);
    sr_chk("R1 latch untouched when deselected");

    // R4 R6 latch set/clear
    op1(8'h06); sr_chk("R6 latch visible");
    op1(8'h04); sr_chk("R4 latch cleared by 04h");

    // R2 trailing bytes ignored
    cs_lo(); byte_x(8'h04, 8, 1'b0, r); byte_x(8'h06, 8, 1'b0, r); cs_hi();
    sr_chk("R2 second byte ignored");
    cs_lo(); byte_x(8'h06, 8, 1'b0, r); byte_x(8'h04, 8, 1'b0, r); cs_hi();
    wel_m = 1'b1;
    sr_chk("R2 trailing 04h ignored");
    op1(8'h04);

    // R4 write without latch
    buf_d[0] = 8'hAA;
    wr_mem(16'h0010, 1);
    rd_mem(16'h0010, 1, 8, 8, "R4 write blocked without latch");

    // R4 R3 write then read
    op1(8'h06);
    buf_d[0] = 8'hAA; buf_d[1] = 8'h55; buf_d[2] = 8'h81;
    wr_mem(16'h0010, 3);
    rd_mem(16'h0010, 3, 8, 8, "R3 read data");
    sr_chk("R4 latch cleared after write frame");

    // R5 wrap
    op1(8'h06);
    buf_d[0] = 8'h11; buf_d[1] = 8'h22; buf_d[2] = 8'h33;
    wr_mem(16'h00FF, 3);
    rd_mem(16'h00FE, 4, 8, 8, "R5 wrap");

    // R10 aliasing
    op1(8'h06);
    buf_d[0] = 8'h7E;
    wr_mem(16'hA140, 1);
    rd_mem(16'h0040, 1, 8, 8, "R10 alias");

    // R7 protect lock
    op1(8'h06); wrsr(8'h80); sr_chk("R7 lock set");
    wp_n = 1'b0;
    op1(8'h06); wrsr(8'h0C); sr_chk("R7 status frozen");
    wp_n = 1'b1;
    op1(8'h06); wrsr(8'h0C); sr_chk("R7 status writable with pin high");

    // R8 regions
    buf_d[0] = 8'hE1;
    op1(8'h06); wr_mem(16'h0020, 1);
    rd_mem(16'h0020, 1, 8, 8, "R8 all protected");
    op1(8'h06); wrsr(8'h04); sr_chk("R8 quarter set");
    buf_d[0] = 8'h3C; buf_d[1] = 8'hC3;
    op1(8'h06); wr_mem(16'h00BF, 2);
    rd_mem(16'h00BF, 2, 8, 8, "R8 quarter boundary");
    op1(8'h06); wrsr(8'h08);
    buf_d[0] = 8'h5A; buf_d[1] = 8'hA5;
    op1(8'h06); wr_mem(16'h007F, 2);
    rd_mem(16'h007F, 2, 8, 8, "R8 half boundary");
    op1(8'h06); wrsr(8'h00); sr_chk("R8 regions cleared");

    // R9 pause in read and in write address
    rd_mem(16'h0010, 3, 1, 3, "R9 resume read");
    buf_d[0] = 8'h96;
    op1(8'h06);
    cs_lo(); byte_x(8'h02, 5, 1'b0, r); byte_x(8'h00, 8, 1'b0, r); byte_x(8'h30, 2, 1'b0, r);
    byte_x(buf_d[0], 7, 1'b0, r); cs_hi();
    mem_m[8'h30] = 8'h96; wel_m = 1'b0;
    rd_mem(16'h0030, 1, 0, 0, "R9 resume write");

    // random traffic
    for (int t = 0; t < 24; t++) begin
      logic [15:0] a;
      int n;
      a = 16'($urandom);
      n = 1 + int'($urandom % 4);
      for (int i = 0; i < n; i++) buf_d[i] = 8'($urandom);
      if ($urandom % 4 != 0) op1(8'h06);
      wr_mem(a, n);
      rd_mem({8'($urandom), a[7:0]}, n, int'($urandom % 5), int'($urandom % 8), "R5 random stream");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule